// File: doc/BRIEF.md
# Up/Down Auto-Reload Timer with Clock Output

This block is a 16-bit timer built from two equal halves. A companion 16-bit reload register supplies the value loaded when the timer wraps. In its normal auto-reload mode the timer advances once every twelve oscillator ticks when it runs on the internal clock. When counter mode is selected, it advances once per external event pulse instead. A down-count enable in the mode register hands the counting direction to an external direction pin. Counting up, the timer wraps past all-ones and loads the reload value. Counting down, it wraps when it reaches the reload value and loads all-ones. Each wrap raises an overflow flag. In down-count mode each wrap also flips a separate external flag.

Clock-out mode is selected by internal timing together with the output-enable bit. In this mode the timer always counts up, advances once every two oscillator ticks, and toggles a clock pin on every wrap. The result is a square wave at the oscillator rate divided by four times the count range. These wraps raise no flag. Software loads the counter, the reload register, the mode bits and the flags through a small byte-wide write port. The counter value is brought out continuously.

Top module: `wrap_timer16`

## Requirements
- R1: A synchronous active-high reset clears the counter, the reload register, both mode bits, both flags and the clock pin to 0.
- R2: On internal timing in auto-reload mode, the counter moves one step for every 12 oscillator ticks while the run input is high. With the run input low it holds its value, and the tick count restarts from zero.
- R3: Counting up from FFFFh, a step loads the reload register into the counter and sets the overflow flag.
- R4: With mode bit 0 (down-count enable) set and the direction pin low, each step decrements the counter. A step taken while the counter equals the reload register loads FFFFh and sets the overflow flag.
- R5: With mode bit 0 set, outside clock-out mode, the external flag inverts on every wrap in either direction. With mode bit 0 clear it changes only by a software write.
- R6: Clock-out mode applies when the counter/timer select is 0 and mode bit 1 is 1. In this mode the counter counts up once every 2 oscillator ticks and the clock pin inverts on each wrap, so each pin level lasts 2 x (65536 - reload) clocks. Wraps leave both flags unchanged. Outside this mode the clock pin is 0.
- R7: With the counter/timer select at 1, the counter steps once per clock cycle in which the external event input and the run input are both high. Oscillator ticks are ignored in this setting, and mode bit 1 does not select clock-out mode.
- R8: The reload register is read at the moment of a wrap, so a write to it takes effect at the next wrap. A counter write in a cycle replaces the step of that cycle, and the half that is not written keeps its value.
- R9: Write select codes are 0 counter low byte, 1 counter high byte, 2 reload low byte, 3 reload high byte, 4 mode, and 5 flags. A mode write takes bit 1 as the output enable and bit 0 as the down-count enable and ignores the other bits. A flags write puts bit 0 into the overflow flag and bit 1 into the external flag. Codes 6 and 7 have no effect. A wrap in the same cycle as a flags write is applied on top of the written value.
- R10: With mode bit 0 clear, the direction pin is ignored and the timer counts up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator tick |
| run_en | input | 1 | Run enable; low stops the timer |
| cnt_sel | input | 1 | 0 internal timing, 1 external event counting |
| ext_evt | input | 1 | External event pulse, one count per high cycle |
| dir_in | input | 1 | Direction pin: 1 up, 0 down (with down-count enabled) |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | HALF_W | Write data |
| count_q | output | 2*HALF_W | Current counter value |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External (wrap-toggle) flag |
| clk_out | output | 1 | Clock-out pin |

## Verification
The assertions take for granted that event and tick inputs are single-cycle qualifiers sampled at the clock. They also assume that a software write is the only other source of change to the counter and the flags. For this reason every property that expects a wrap result is gated off in cycles that carry a counter or flag write. The random stimulus mixes writes, run gaps, mode changes and direction flips freely. Reload and counter values are biased toward the top of the range, so that wraps in both directions and clock-out toggles occur often within the run. Directed sequences then pin exact wrap cycles, underflow at the reload value and the clock-out half period.

// File: rtl/wtmr_pkg.sv
package wtmr_pkg;

    // Register select codes; the write decoder depends on this numbering.
    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_RLD_LO = 3'd2,
        SEL_RLD_HI = 3'd3,
        SEL_MODE   = 3'd4,
        SEL_FLAGS  = 3'd5
    } sel_e;

    typedef enum logic {
        OP_RELOAD = 1'b0,
        OP_CLKOUT = 1'b1
    } op_e;

    typedef struct packed {
        logic out_en;   // bit 1
        logic dn_en;    // bit 0
    } mode_t;

    typedef struct packed {
        logic ovf;      // bit 0 of a flags write
        logic ext;      // bit 1 of a flags write
    } flags_t;

    function automatic op_e pick_op(input logic cnt_sel, input mode_t m);
        return (!cnt_sel && m.out_en) ? OP_CLKOUT : OP_RELOAD;
    endfunction

    function automatic logic count_up(input op_e op, input mode_t m, input logic dir);
        return (op == OP_CLKOUT) || !m.dn_en || dir;
    endfunction

endpackage

// File: rtl/wtmr_presc.sv
module wtmr_presc #(
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    input  logic fast,
    output logic step
);
    localparam int MAXDIV = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int PW     = (MAXDIV > 2) ? $clog2(MAXDIV) : 1;
    localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);
    localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);

    logic [PW-1:0] pcnt_q;
    logic [PW-1:0] lim;
    logic          at_lim;

    always_comb begin
        lim    = fast ? FAST_LIM : SLOW_LIM;
        at_lim = (pcnt_q >= lim);
        step   = run && tick && at_lim;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pcnt_q <= '0;
        end else if (tick) begin
            pcnt_q <= at_lim ? '0 : pcnt_q + 1'b1;
        end
    end

    // R2: a stopped prescaler produces no step and sits at zero
    a_r2_stop_clears: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pcnt_q == '0));

endmodule

// File: rtl/wtmr_core.sv
module wtmr_core #(
    parameter int HALF_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                step,
    input  logic                up,
    input  logic [1:0]          half_wr,
    input  logic [HALF_W-1:0]   wdata,
    input  logic [2*HALF_W-1:0] reload,
    output logic [2*HALF_W-1:0] cnt_q,
    output logic                wrap_ev
);
    localparam int NH = 2;
    localparam int W  = NH * HALF_W;
    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] stepped;
    logic [W-1:0] nxt;
    logic         any_wr;
    logic         at_edge;

    always_comb begin
        any_wr  = |half_wr;
        at_edge = up ? (cnt_q == ONES) : (cnt_q == reload);
        wrap_ev = step && at_edge && !any_wr;
        if (at_edge) stepped = up ? reload : ONES;
        else         stepped = up ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end

    for (genvar h = 0; h < NH; h++) begin : g_half
        assign nxt[h*HALF_W +: HALF_W] = half_wr[h] ? wdata :
                                         (any_wr ? cnt_q[h*HALF_W +: HALF_W]
                                                 : stepped[h*HALF_W +: HALF_W]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (any_wr || step) begin
            cnt_q <= nxt;
        end
    end

    // R3: up wrap loads the reload value
    a_r3_up_reload: assert property (@(posedge clk) disable iff (rst)
        (step && up && !any_wr && cnt_q == ONES) |=> (cnt_q == $past(reload)));

    // R4: down wrap at the reload value loads all-ones
    a_r4_down_ones: assert property (@(posedge clk) disable iff (rst)
        (step && !up && !any_wr && cnt_q == reload) |=> (cnt_q == ONES));

    // R2: no step and no write means the counter holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!step && !any_wr) |=> $stable(cnt_q));

    // R8: a counter write overrides the step of that cycle
    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        half_wr[0] |=> (cnt_q[HALF_W-1:0] == $past(wdata)));

endmodule

// File: rtl/wtmr_flags.sv
module wtmr_flags
    import wtmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   flag_wr,
    input  flags_t wr_val,
    input  logic   wrap_ev,
    input  op_e    op,
    input  logic   dn_en,
    input  logic   pin_toggle_en,
    output logic   ovf_q,
    output logic   ext_q,
    output logic   pin_q
);
    flags_t base;
    logic   flag_wrap;

    always_comb begin
        base      = flag_wr ? wr_val : '{ovf: ovf_q, ext: ext_q};
        flag_wrap = wrap_ev && (op == OP_RELOAD);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            ovf_q <= base.ovf | flag_wrap;
            ext_q <= base.ext ^ (flag_wrap && dn_en);
        end
    end

    // Clock-out pin: inverts on each wrap, held low outside clock-out mode.
    always_ff @(posedge clk) begin
        if (rst || !pin_toggle_en) begin
            pin_q <= 1'b0;
        end else if (wrap_ev) begin
            pin_q <= ~pin_q;
        end
    end

    // R5: down-count wrap inverts the external flag
    a_r5_ext_toggle: assert property (@(posedge clk) disable iff (rst)
        (wrap_ev && dn_en && op == OP_RELOAD && !flag_wr) |=> (ext_q != $past(ext_q)));

    // R5: with down-count disabled only software moves the external flag
    a_r5_ext_hold: assert property (@(posedge clk) disable iff (rst)
        (!dn_en && !flag_wr) |=> $stable(ext_q));

    // R3: a wrap in auto-reload mode leaves the overflow flag set
    a_r3_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (wrap_ev && op == OP_RELOAD) |=> ovf_q);

    // R6: clock-out wraps never raise the overflow flag
    a_r6_no_ovf: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLKOUT && !flag_wr) |=> !$rose(ovf_q));

    // R6: the pin only moves on a wrap while clock-out is active
    a_r6_pin_steady: assert property (@(posedge clk) disable iff (rst)
        (pin_toggle_en && !wrap_ev) |=> $stable(pin_q));

endmodule

// File: rtl/wrap_timer16.sv
module wrap_timer16
    import wtmr_pkg::*;
#(
    parameter int HALF_W   = 8,
    parameter int SLOW_DIV = 12,
    parameter int FAST_DIV = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                osc_tick,
    input  logic                run_en,
    input  logic                cnt_sel,
    input  logic                ext_evt,
    input  logic                dir_in,
    input  logic                reg_wr,
    input  logic [2:0]          reg_sel,
    input  logic [HALF_W-1:0]   reg_wdata,
    output logic [2*HALF_W-1:0] count_q,
    output logic                ovf_flag,
    output logic                ext_flag,
    output logic                clk_out
);
    localparam int W = 2 * HALF_W;

    mode_t        mode_q;
    logic [W-1:0] reload_q;
    op_e          op;
    logic         up;
    logic         presc_step;
    logic         step;
    logic [1:0]   half_wr;
    logic         flag_wr;
    flags_t       flag_val;
    logic         wrap_ev;

    always_comb begin
        op         = pick_op(cnt_sel, mode_q);
        up         = count_up(op, mode_q, dir_in);
        step       = cnt_sel ? (run_en && ext_evt) : presc_step;
        half_wr[0] = reg_wr && (sel_e'(reg_sel) == SEL_CNT_LO);
        half_wr[1] = reg_wr && (sel_e'(reg_sel) == SEL_CNT_HI);
        flag_wr    = reg_wr && (sel_e'(reg_sel) == SEL_FLAGS);
        flag_val   = '{ovf: reg_wdata[0], ext: reg_wdata[1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reload_q <= '0;
            mode_q   <= '0;
        end else if (reg_wr) begin
            case (sel_e'(reg_sel))
                SEL_RLD_LO: reload_q[HALF_W-1:0] <= reg_wdata;
                SEL_RLD_HI: reload_q[W-1:HALF_W] <= reg_wdata;
                SEL_MODE:   mode_q <= '{out_en: reg_wdata[1], dn_en: reg_wdata[0]};
                default: ;
            endcase
        end
    end

    wtmr_presc #(.SLOW_DIV(SLOW_DIV), .FAST_DIV(FAST_DIV)) u_presc (
        .clk  (clk),
        .rst  (rst),
        .run  (run_en && !cnt_sel),
        .tick (osc_tick),
        .fast (op == OP_CLKOUT),
        .step (presc_step)
    );

    wtmr_core #(.HALF_W(HALF_W)) u_core (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .up      (up),
        .half_wr (half_wr),
        .wdata   (reg_wdata),
        .reload  (reload_q),
        .cnt_q   (count_q),
        .wrap_ev (wrap_ev)
    );

    wtmr_flags u_flags (
        .clk           (clk),
        .rst           (rst),
        .flag_wr       (flag_wr),
        .wr_val        (flag_val),
        .wrap_ev       (wrap_ev),
        .op            (op),
        .dn_en         (mode_q.dn_en),
        .pin_toggle_en (op == OP_CLKOUT),
        .ovf_q         (ovf_flag),
        .ext_q         (ext_flag),
        .pin_q         (clk_out)
    );

    // R7: in event-counting mode oscillator ticks never move the counter
    a_r7_events_only: assert property (@(posedge clk) disable iff (rst)
        (cnt_sel && !ext_evt && !half_wr[0] && !half_wr[1]) |=> $stable(count_q));

    // R10: with down-count disabled the counter never decrements on a plain step
    a_r10_up_only: assert property (@(posedge clk) disable iff (rst)
        (!mode_q.dn_en && step && !reg_wr && count_q != '1) |=> (count_q == $past(count_q) + 1'b1));

endmodule

// File: tb/wrap_timer16_test.sv
module wrap_timer16_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        osc_tick, run_en, cnt_sel, ext_evt, dir_in, reg_wr;
    logic [2:0]  reg_sel;
    logic [7:0]  reg_wdata;
    logic [15:0] count_q;
    logic        ovf_flag, ext_flag, clk_out;

    int n_chk = 0;
    int n_bad = 0;

    // bench reference state
    logic [15:0] m_cnt, m_rld;
    logic [1:0]  m_mode;
    logic        m_ovf, m_ext, m_pin;
    int          m_presc;

    wrap_timer16 uut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .run_en(run_en),
        .cnt_sel(cnt_sel), .ext_evt(ext_evt), .dir_in(dir_in),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .count_q(count_q), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .clk_out(clk_out)
    );

    always #4 clk = ~clk;   // 125 MHz

    function automatic int half_period(input logic [15:0] rld);
        return 2 * (65536 - int'(rld));
    endfunction

    // Reference model written from the requirements.
    always @(posedge clk) begin
        logic co, up, stp, cw, wrp;
        int   lim;
        if (rst) begin
            m_cnt = 0; m_rld = 0; m_mode = 0; m_ovf = 0; m_ext = 0; m_pin = 0; m_presc = 0;
        end else begin
            co  = !cnt_sel && m_mode[1];
            up  = co || !m_mode[0] || dir_in;
            lim = co ? 1 : 11;
            stp = 0;
            if (cnt_sel) begin
                stp = run_en && ext_evt; m_presc = 0;
            end else if (!run_en) begin
                m_presc = 0;
            end else if (osc_tick) begin
                if (m_presc >= lim) begin stp = 1; m_presc = 0; end
                else m_presc = m_presc + 1;
            end
            cw  = reg_wr && (reg_sel == 3'd0 || reg_sel == 3'd1);
            wrp = stp && !cw && (up ? (m_cnt == 16'hFFFF) : (m_cnt == m_rld));
            if (cw) begin
                if (reg_sel == 3'd0) m_cnt[7:0] = reg_wdata; else m_cnt[15:8] = reg_wdata;
            end else if (stp) begin
                if (wrp) m_cnt = up ? m_rld : 16'hFFFF;
                else     m_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
            end
            if (reg_wr && reg_sel == 3'd5) begin m_ovf = reg_wdata[0]; m_ext = reg_wdata[1]; end
            if (wrp && !co) begin m_ovf = 1'b1; if (m_mode[0]) m_ext = ~m_ext; end
            if (!co) m_pin = 1'b0; else if (wrp) m_pin = ~m_pin;
            if (reg_wr && reg_sel == 3'd2) m_rld[7:0]  = reg_wdata;
            if (reg_wr && reg_sel == 3'd3) m_rld[15:8] = reg_wdata;
            if (reg_wr && reg_sel == 3'd4) m_mode = reg_wdata[1:0];
        end
    end

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        check("R3 R4 R8 R10 model count", count_q, m_cnt);
        check("R3 R5 R9 model flags", {14'd0, ext_flag, ovf_flag}, {14'd0, m_ext, m_ovf});
        check("R6 R7 model clk_out", {15'd0, clk_out}, {15'd0, m_pin});
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        cmp_model();
    endtask

    task automatic run_n(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        cyc();
        reg_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int last, gap;
        logic prev;
        void'($urandom(32'd20240611));
        rst = 1; osc_tick = 0; run_en = 0; cnt_sel = 0; ext_evt = 0; dir_in = 0;
        reg_wr = 0; reg_sel = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        @(negedge clk);
        // R1 reset state
        check("R1 count", count_q, 16'h0000);
        check("R1 flags", {14'd0, ext_flag, ovf_flag}, 16'd0);
        check("R1 clk_out", {15'd0, clk_out}, 16'd0);

        // R9 R3: up wrap loads reload
        wr(3'd0, 8'hF0); wr(3'd1, 8'hFF); wr(3'd2, 8'h34); wr(3'd3, 8'h12);
        osc_tick = 1; run_en = 1;
        run_n(12 * 15);
        check("R2 twelve ticks per step", count_q, 16'hFFFF);
        check("R3 no flag before wrap", {15'd0, ovf_flag}, 16'd0);
        run_n(12);
        check("R3 up wrap loads reload", count_q, 16'h1234);
        check("R3 overflow set", {15'd0, ovf_flag}, 16'd1);

        // R2 stopped timer holds
        run_en = 0;
        run_n(40);
        check("R2 run low holds", count_q, 16'h1234);

        // R4 R5 down count underflow at reload
        wr(3'd5, 8'h00); wr(3'd4, 8'h01); wr(3'd0, 8'h36);
        dir_in = 0; run_en = 1;
        run_n(24);
        check("R4 decrement", count_q, 16'h1234);
        run_n(12);
        check("R4 underflow loads FFFF", count_q, 16'hFFFF);
        check("R4 R5 flags after underflow", {14'd0, ext_flag, ovf_flag}, 16'd3);

        // R10 direction ignored with down-count off
        run_en = 0;
        wr(3'd4, 8'hFC); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        run_en = 1;
        run_n(36);
        check("R10 counts up with dir low", count_q, 16'h0003);
        check("R9 upper mode bits ignored", {15'd0, clk_out}, 16'd0);

        // R8 reload written mid-way used at next wrap
        run_en = 0;
        wr(3'd0, 8'hFE); wr(3'd1, 8'hFF);
        run_en = 1;
        run_n(12);
        wr(3'd2, 8'h78); wr(3'd3, 8'h56);
        run_n(10);
        check("R8 new reload at wrap", count_q, 16'h5678);

        // R7 event counting ignores ticks and clock-out bit
        run_en = 0;
        wr(3'd4, 8'h02); wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        cnt_sel = 1; run_en = 1;
        run_n(30);
        check("R7 ticks ignored", count_q, 16'h0000);
        for (int i = 0; i < 5; i++) begin ext_evt = 1; cyc(); ext_evt = 0; cyc(); end
        check("R7 five events", count_q, 16'h0005);
        check("R7 no clock-out in counter mode", {15'd0, clk_out}, 16'd0);

        // R6 clock-out half period and no flag
        cnt_sel = 0; run_en = 0;
        wr(3'd5, 8'h00); wr(3'd2, 8'hFA); wr(3'd3, 8'hFF); wr(3'd0, 8'hFA); wr(3'd1, 8'hFF);
        run_en = 1;
        last = -1; gap = 0; prev = clk_out;
        for (int i = 0; i < 200; i++) begin
            cyc();
            if (clk_out != prev) begin
                if (last >= 0) gap = i - last;
                last = i;
            end
            prev = clk_out;
        end
        check("R6 half period", 16'(gap), 16'(half_period(16'hFFFA)));
        check("R6 no overflow in clock-out", {15'd0, ovf_flag}, 16'd0);

        // Random phase against the reference model
        for (int i = 0; i < 4000; i++) begin
            osc_tick = ($urandom_range(9) < 7);
            run_en   = ($urandom_range(19) != 0);
            cnt_sel  = ($urandom_range(9) == 0);
            ext_evt  = $urandom_range(1);
            dir_in   = ($urandom_range(7) != 0) ? dir_in : ~dir_in;
            reg_wr   = ($urandom_range(24) == 0);
            reg_sel  = 3'($urandom_range(7));
            reg_wdata = (reg_sel == 3'd1 || reg_sel == 3'd3) ? 8'($urandom_range(255, 248))
                                                             : 8'($urandom_range(255));
            cyc();
        end
        reg_wr = 0;

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule